// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog that counts ticks and, if software fails to clear it in time, raises a reset. Ticks come either from an external free-running watchdog oscillator tick (`osc_tick`, one-cycle enable pulses) or from an internal instruction tick that fires once every four system clocks. The internal tick stops while the core is halted. Every tick passes through a fixed divide-by-256 stage and then a prescaler. A 3-bit select field in an 8-bit control register sets the prescaler ratio. The other five bits of that register are free flag bits for software.

Software restarts the count with clear strobes. In single mode one strobe (`clr_single`) is enough. In paired mode two distinct strobes (`clr_first`, `clr_second`) must both have been seen. Entering halt and the external reset also clear the count. A timeout while running gives a one-cycle full chip reset pulse and sets a sticky timeout flag. A timeout while halted gives only a one-cycle warm reset pulse, meant to restart the program counter and stack pointer. Three static option inputs enable the watchdog, pick the tick source and pick the clear mode.

Top module: `guard_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `reg_rdata` reads 0x07, and `to_flag`, `chip_rst` and `warm_rst` are low. Any half-seen clear pair is dropped.
- R2: The ratio select field is `reg_rdata[2:0]`; value s gives a ratio of 2^s. A timeout pulse appears in the cycle after the edge that takes the 256×2^s-th tick counted after a clear.
- R3: Bits 7:3 of the control register read back what was last written and have no effect on timing. A write shows on `reg_rdata` from the next cycle.
- R4: A timeout with `halt` low gives `chip_rst` high for exactly one cycle and sets `to_flag` in the same cycle. `to_flag` stays high until `rst_n` is low or a software clear takes effect.
- R5: After a timeout, the divider and the prescaler restart from zero. The next timeout follows one full period later with no clear needed.
- R6: A timeout with `halt` high gives `warm_rst` high for exactly one cycle. `chip_rst` stays low and `to_flag` is not changed.
- R7: A rising edge on `halt` clears the divider and the prescaler at that clock edge.
- R8: With `cfg_src_osc`=1, ticks are `osc_tick`. With `cfg_src_osc`=0, ticks come every fourth system clock and stop while `halt` is high; `osc_tick` is then ignored.
- R9: With `cfg_enable`=0, the count is held at zero, no reset pulse occurs and clear strobes have no effect.
- R10: With `cfg_dual_clear`=0, `clr_single` clears the count at the edge that samples it. `clr_first` and `clr_second` are ignored.
- R11: With `cfg_dual_clear`=1, the count clears at the edge where both `clr_first` and `clr_second` have been seen, in either order or in the same cycle. Repeating one of them does not complete the pair, and `clr_single` is ignored. Pending halves are dropped when the clear takes effect or a timeout occurs.
- R12: Any register write clears the prescaler at that edge. The divide-by-256 stage keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, sampled on `clk` |
| cfg_enable | input | 1 | Option: watchdog enabled |
| cfg_src_osc | input | 1 | Option: 1 = oscillator ticks, 0 = instruction tick (clk/4) |
| cfg_dual_clear | input | 1 | Option: 1 = paired clear, 0 = single clear |
| osc_tick | input | 1 | Tick enable from the watchdog oscillator |
| halt | input | 1 | Core halted (level) |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| clr_single | input | 1 | Single clear command strobe |
| clr_first | input | 1 | First clear command strobe (paired mode) |
| clr_second | input | 1 | Second clear command strobe (paired mode) |
| to_flag | output | 1 | Sticky timeout status |
| chip_rst | output | 1 | One-cycle full chip reset pulse |
| warm_rst | output | 1 | One-cycle warm reset pulse |

## Verification
A clear, a halt entry or a register write acts at the same rising edge that samples it. A timeout is decided at the edge that takes the last tick, and its pulse and the status flag appear in the next cycle. Register writes show on the read port one cycle later. The bench drives inputs and samples outputs on falling edges and counts falling edges from the one that drove a clear. A period of P ticks at one tick per clock is therefore expected at count P+1, a clear sampled at count i moves the pulse to i+257, and a run that follows a pulse ends exactly P (or P−1) falling edges later. The instruction-tick phase is not visible at the ports, so that case is checked against a four-cycle window.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [1:0] {
    TMO_NONE = 2'd0,
    TMO_CHIP = 2'd1,
    TMO_WARM = 2'd2
  } tmo_kind_e;
endpackage

// File: rtl/gt_tick_sel.sv
module gt_tick_sel #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_osc,
  input  logic osc_tick,
  input  logic halt,
  output logic tick
);
  logic [DIV_W-1:0] div_q;
  logic             ins_tick;

  // instruction tick: one pulse every 2**DIV_W clocks, frozen while halted
  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (!halt) div_q <= div_q + 1'b1;
  end

  assign ins_tick = (&div_q) && !halt;
  assign tick     = src_osc ? osc_tick : ins_tick;
endmodule

// File: rtl/gt_clear_ctl.sv
module gt_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dual,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  input  logic halt,
  input  logic fire,
  output logic sw_clr,
  output logic cnt_clr
);
  logic halt_q;
  logic got_a_q, got_b_q;
  logic pair_done;
  logic halt_entry;

  assign pair_done  = (got_a_q || clr_first) && (got_b_q || clr_second);
  assign sw_clr     = enable && (dual ? pair_done : clr_single);
  assign halt_entry = halt && !halt_q;
  assign cnt_clr    = sw_clr || halt_entry;

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || !dual || sw_clr || fire) begin
      got_a_q <= 1'b0;
      got_b_q <= 1'b0;
    end else begin
      if (clr_first)  got_a_q <= 1'b1;
      if (clr_second) got_b_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gt_count.sv
module gt_count
  import gt_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             clr,
  input  logic             pre_clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             halt,
  output logic             fire,
  output tmo_kind_e        kind_q
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [BASE_W-1:0] base_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  limit;
  logic              base_end, pre_end;

  // thermometer limit: 2**sel - 1
  for (genvar g = 0; g < PRE_W; g++) begin : g_lim
    assign limit[g] = (sel > SEL_W'(g));
  end

  assign base_end = &base_q;
  assign pre_end  = (pre_q == limit);
  assign fire     = enable && !clr && tick && base_end && pre_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || clr) begin
      base_q <= '0;
      pre_q  <= '0;
    end else begin
      if (tick) begin
        base_q <= base_q + 1'b1;
        if (base_end) begin
          if (pre_end) pre_q <= '0;
          else         pre_q <= pre_q + 1'b1;
        end
      end
      if (pre_clr) pre_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    kind_q <= TMO_NONE;
    else if (fire) kind_q <= halt ? TMO_WARM : TMO_CHIP;
    else           kind_q <= TMO_NONE;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int          REG_W    = 8,
  parameter int          SEL_W    = 3,
  parameter int          BASE_W   = 8,
  parameter int          INS_DIVW = 2,
  parameter logic [7:0]  REG_INIT = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_src_osc,
  input  logic             cfg_dual_clear,
  input  logic             osc_tick,
  input  logic             halt,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             clr_single,
  input  logic             clr_first,
  input  logic             clr_second,
  output logic             to_flag,
  output logic             chip_rst,
  output logic             warm_rst
);
  logic [REG_W-1:0] ctrl_q;
  logic             tick, fire, sw_clr, cnt_clr;
  tmo_kind_e        kind;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= REG_W'(REG_INIT);
    else if (reg_wr) ctrl_q <= reg_wdata;
  end
  assign reg_rdata = ctrl_q;

  gt_tick_sel #(.DIV_W(INS_DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_osc(cfg_src_osc),
    .osc_tick(osc_tick), .halt(halt), .tick(tick)
  );

  gt_clear_ctl u_clr (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .dual(cfg_dual_clear),
    .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
    .halt(halt), .fire(fire), .sw_clr(sw_clr), .cnt_clr(cnt_clr)
  );

  gt_count #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .tick(tick),
    .clr(cnt_clr), .pre_clr(reg_wr), .sel(ctrl_q[SEL_W-1:0]),
    .halt(halt), .fire(fire), .kind_q(kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              to_flag <= 1'b0;
    else if (fire && !halt)  to_flag <= 1'b1;
    else if (sw_clr)         to_flag <= 1'b0;
  end

  assign chip_rst = (kind == TMO_CHIP);
  assign warm_rst = (kind == TMO_WARM);
endmodule

// File: rtl/gt_checker.sv
module gt_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             halt,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             to_flag,
  input logic             chip_rst,
  input logic             warm_rst
);
  p_chip_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  p_chip_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> to_flag);

  p_warm_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !warm_rst);

  p_warm_only_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> $past(halt));

  p_kinds_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_rst && warm_rst));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !chip_rst && !warm_rst);

  p_flags_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[REG_W-1:3] == $past(reg_wdata[REG_W-1:3]));
endmodule

bind guard_timer gt_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .halt(halt),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .to_flag(to_flag), .chip_rst(chip_rst), .warm_rst(warm_rst)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b1, cfg_src_osc = 1'b1, cfg_dual_clear = 1'b0;
  logic osc_tick = 1'b1, halt = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
  logic to_flag, chip_rst, warm_rst;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  guard_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_osc(cfg_src_osc),
    .cfg_dual_clear(cfg_dual_clear), .osc_tick(osc_tick), .halt(halt),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
    .to_flag(to_flag), .chip_rst(chip_rst), .warm_rst(warm_rst)
  );

  localparam int NVEC = 5;
  localparam bit [2:0] SEL_TAB [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
  localparam int       EXP_TAB [NVEC] = '{257, 513, 1025, 2049, 8193};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // 0 none, 1 single, 2 first, 3 second, 4 halt on, 5 pair, 6 write 0x01
  task automatic drive(input int kind);
    case (kind)
      1: clr_single = 1'b1;
      2: clr_first  = 1'b1;
      3: clr_second = 1'b1;
      4: halt       = 1'b1;
      5: begin clr_first = 1'b1; clr_second = 1'b1; end
      6: begin reg_wr = 1'b1; reg_wdata = 8'h01; end
      default: ;
    endcase
  endtask

  task automatic kick();
    @(negedge clk);
    if (cfg_dual_clear) drive(5); else drive(1);
  endtask

  task automatic watch(input int lim, input int at1, input int k1,
                       input int at2, input int k2,
                       output int n, output bit got_chip, output bit got_warm);
    n = 0; got_chip = 0; got_warm = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; reg_wr = 1'b0;
      if (chip_rst || warm_rst) begin
        n = i; got_chip = chip_rst; got_warm = warm_rst;
        break;
      end
      if (i == at1) drive(k1);
      if (i == at2) drive(k2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 190000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n; bit c; bit w;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h07, "R1 rdata", reg_rdata, 8'h07);
    chk(!to_flag && !chip_rst && !warm_rst, "R1 outputs", {to_flag, chip_rst, warm_rst}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h07 && !to_flag, "R1 after release", reg_rdata, 8'h07);

    // R2/R3/R4 vector table
    for (int k = 0; k < NVEC; k++) begin
      wr({5'b10101, SEL_TAB[k]});
      chk(reg_rdata == {5'b10101, SEL_TAB[k]}, "R3 readback", reg_rdata, {5'b10101, SEL_TAB[k]});
      kick();
      watch(20000, 0, 0, 0, 0, n, c, w);
      chk(n == EXP_TAB[k] && c && !w, "R2 period", n, EXP_TAB[k]);
      chk(to_flag == 1'b1, "R4 flag set", to_flag, 1);
    end

    // R4 single pulse, R5 restart
    wr(8'h00);
    kick();
    watch(1000, 0, 0, 0, 0, n, c, w);
    chk(n == 257 && c, "R2 sel0", n, 257);
    @(negedge clk);
    chk(!chip_rst && to_flag, "R4 one-cycle pulse, flag held", {chip_rst, to_flag}, 1);
    watch(1000, 0, 0, 0, 0, n, c, w);
    chk(n == 255 && c, "R5 restart without clear", n, 255);
    @(negedge clk); clr_single = 1'b1;
    @(negedge clk); clr_single = 1'b0;
    chk(to_flag == 1'b0, "R4 flag cleared by software", to_flag, 0);

    // R12 register write clears prescaler only
    wr(8'h01);
    kick();
    watch(2000, 300, 6, 0, 0, n, c, w);
    chk(n == 769, "R12 prescaler cleared on write", n, 769);

    // R7 halt entry clears, R6 warm reset in halt
    wr(8'h00);
    kick();
    watch(1000, 100, 4, 0, 0, n, c, w);
    chk(n == 357 && w && !c, "R7/R6 halt clear then warm reset", n, 357);
    chk(to_flag == 1'b0, "R6 flag untouched", to_flag, 0);
    @(negedge clk); halt = 1'b0;

    // R10 single mode
    kick();
    watch(1000, 100, 2, 120, 3, n, c, w);
    chk(n == 257, "R10 paired strobes ignored", n, 257);
    kick();
    watch(1000, 100, 1, 0, 0, n, c, w);
    chk(n == 357, "R10 single clear", n, 357);

    // R11 paired mode
    @(negedge clk); cfg_dual_clear = 1'b1;
    kick();
    watch(1000, 100, 2, 150, 2, n, c, w);
    chk(n == 257, "R11 repeated first does not clear", n, 257);
    kick();
    watch(1000, 100, 3, 150, 2, n, c, w);
    chk(n == 407, "R11 reverse order clears", n, 407);
    kick();
    watch(1000, 100, 1, 0, 0, n, c, w);
    chk(n == 257, "R11 single ignored", n, 257);
    kick();
    watch(1000, 100, 5, 0, 0, n, c, w);
    chk(n == 357, "R11 same-cycle pair", n, 357);
    @(negedge clk); cfg_dual_clear = 1'b0;

    // R8 instruction tick source
    @(negedge clk); cfg_src_osc = 1'b0;
    kick();
    watch(1500, 0, 0, 0, 0, n, c, w);
    chk(n >= 1022 && n <= 1025 && c, "R8 instruction tick period", n, 1024);
    @(negedge clk); halt = 1'b1;
    watch(3000, 0, 0, 0, 0, n, c, w);
    chk(n == 0, "R8 halted instruction tick stops", n, 0);
    @(negedge clk); halt = 1'b0; cfg_src_osc = 1'b1;

    // R9 disabled
    @(negedge clk); cfg_enable = 1'b0;
    watch(700, 100, 1, 0, 0, n, c, w);
    chk(n == 0, "R9 no timeout when disabled", n, 0);
    cfg_enable = 1'b1;
    watch(1000, 0, 0, 0, 0, n, c, w);
    chk(n == 256, "R9 count held at zero", n, 256);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule